// File: doc/BRIEF.md
# UART Xon/Xoff Software Flow Controller

This block handles in-band flow control for a UART channel. Every character that the serial receiver delivers is examined against four programmable flow characters: two "resume" codes (ON1, ON2) and two "stop" codes (OFF1, OFF2). A 4-bit mode field selects which codes count, and whether each must arrive alone or as a two-character pair. A recognised stop code raises `tx_halt`. The local transmitter samples that level before it starts each character, so the character already on the line finishes. A recognised resume code drops `tx_halt` again. Recognised flow characters are removed from the data stream. Every other character is passed on to the receive FIFO through the forward port.

In the other direction, the block watches two level flags from the receive FIFO. When the fill passes the halt threshold, it asks the transmitter to insert the stop code or codes. When the fill falls back to the resume threshold, it asks for the resume code or codes. Two optional behaviours sit beside this. The first is an "any character resumes" option. The second is a special-character detector that compares against OFF2 and only raises the interrupt flag. All comparisons and inserted characters are cut to the programmed word length.

Stream rules. The insert channel (`ins_valid`/`ins_ready`/`ins_data`) is valid/ready. Once `ins_valid` is high, it stays high with `ins_data` unchanged until `ins_ready` is seen high at a clock edge. A started pair is always sent in full. The receive strobe and the forward port carry no back-pressure, because a serial receiver cannot be stalled. In return, `rx_valid` must never be high in two consecutive cycles. This lets a withheld character and the character after it leave on two successive cycles.

Top module: `sfc_flow_ctrl`

## Requirements
- R1: After reset, `tx_halt`, `xoff_irq`, `ins_valid` and `fwd_valid` are all 0.
- R2: The receive compare is selected by `fc_mode[1:0]` (with `fc_mode[3:2]` as the transmit field):
  - 2'b10 uses ON1/OFF1 only.
  - 2'b01 uses ON2/OFF2 only.
  - 2'b11 with a transmit field of 2'b10 or 2'b01 accepts either code of each kind.
  - 2'b00 compares nothing: every character is forwarded and `tx_halt` never rises.
  - A character that equals both a stop and a resume code counts as stop.
- R3: A recognised stop code raises `tx_halt` in the cycle after its strobe. The stop/resume part of `xoff_irq` is set at the same time, but only when `xoff_irq_en` is 1. `tx_halt` never rises except in the cycle after a strobe.
- R4: A recognised resume code clears `tx_halt` and the stop/resume part of `xoff_irq` in the cycle after its strobe. Recognised flow characters never appear on the forward port.
- R5: Pair mode applies when `fc_mode[1:0]`=2'b11 and the transmit field is 2'b11 or 2'b00. In this mode, a stop needs OFF1 followed by OFF2, and a resume needs ON1 followed by ON2.
  - A first code is withheld from the forward port.
  - If the next character does not complete the pair, the withheld character is forwarded.
  - That next character is then judged as a possible first code.
- R6: With `xon_any_en`=1 while halted, any received character clears `tx_halt` and is forwarded, together with any withheld character.
- R7: With `special_en`=1, a character equal to OFF2 sets the special part of `xoff_irq` (only when `xoff_irq_en`=1). It never halts by itself and is forwarded unless it is a recognised flow code. A pulse on `iir_read` clears the special part one cycle later.
- R8: The transmit field `fc_mode[3:2]` selects what is inserted:
  - 2'b10 inserts ON1/OFF1.
  - 2'b01 inserts ON2/OFF2.
  - 2'b11 inserts OFF1 then OFF2, or ON1 then ON2.
  - 2'b00 inserts nothing.
  - A stop request launches when `rx_above_halt` is 1 and no stop is outstanding. A resume request launches when `rx_at_resume` is 1 and a stop is outstanding.
- R9: `ins_valid` and `ins_data` hold steady until `ins_ready`. A pair is offered first code, then second code, with no idle cycle between them when `ins_ready` stays high.
- R10: `word_len` 2'b00/01/10/11 means 5/6/7/8 data bits. Compares use only that many low bits, and inserted characters have the upper bits cleared.
- R11: A forwarded character appears on `fwd_valid`/`fwd_data` in the cycle after its strobe. When two characters are released at once, the withheld one comes first and the other follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received-character strobe, never high two cycles running |
| rx_data | input | CHAR_W | Received character |
| fc_mode | input | 4 | [3:2] transmit insert select, [1:0] receive compare select |
| xon_any_en | input | 1 | Any character resumes while halted |
| special_en | input | 1 | Enable special-character detection against OFF2 |
| xoff_irq_en | input | 1 | Allow the interrupt flag to set |
| word_len | input | 2 | Data bits: 5 plus this value |
| xon1_char | input | CHAR_W | Resume code ON1 |
| xon2_char | input | CHAR_W | Resume code ON2 |
| xoff1_char | input | CHAR_W | Stop code OFF1 |
| xoff2_char | input | CHAR_W | Stop code OFF2 |
| rx_above_halt | input | 1 | Receive FIFO has passed its halt threshold |
| rx_at_resume | input | 1 | Receive FIFO has reached its resume threshold |
| iir_read | input | 1 | Interrupt identification read pulse |
| ins_ready | input | 1 | Transmitter accepts the offered flow character |
| ins_valid | output | 1 | Flow character offered for insertion |
| ins_data | output | CHAR_W | Flow character to insert, word-length masked |
| fwd_valid | output | 1 | Character forwarded to the receive FIFO |
| fwd_data | output | CHAR_W | Forwarded character |
| tx_halt | output | 1 | Local transmitter must not start a new character |
| xoff_irq | output | 1 | Stop-code or special-character interrupt flag |

## Verification
The bench builds the block with CHAR_W = 8. This is the widest case: all four word lengths are reachable, and the masking cases have real upper bits to remove. The codes are chosen so that ON2 and OFF2 differ from ON1 and OFF1 only in bit 7. At a 5-bit word length, each second code therefore becomes the same as its first code. This exercises both masked compare and masked insertion. Pair mode is driven through aborts that release two characters in a row, and the insert channel is driven with `ins_ready` held low and then toggled in the middle of a pair.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  // receive pair tracker: which first code is being held
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ON1  = 2'd1,
    SEQ_OFF1 = 2'd2
  } seq_t;

  // insert sequencer
  typedef enum logic [1:0] {
    INS_IDLE   = 2'd0,
    INS_FIRST  = 2'd1,
    INS_SECOND = 2'd2
  } ins_t;

  localparam int MIN_WORD_BITS = 5;
endpackage

// File: rtl/sfc_rx_match.sv
module sfc_rx_match import sfc_pkg::*; #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic [CHAR_W-1:0] char_mask,
  input  logic [CHAR_W-1:0] k_on1,
  input  logic [CHAR_W-1:0] k_on2,
  input  logic [CHAR_W-1:0] k_off1,
  input  logic [CHAR_W-1:0] k_off2,
  input  logic [1:0]        rx_sel,
  input  logic [1:0]        tx_sel,
  input  logic              halted,
  input  logic              resume_any_en,
  output logic              off_hit,
  output logic              on_hit,
  output logic              any_resume,
  output logic              fwd_valid,
  output logic [CHAR_W-1:0] fwd_data
);
  logic [CHAR_W-1:0] c;
  logic              use1, use2, paired, either;
  seq_t              state, state_nxt;
  logic [CHAR_W-1:0] held;
  logic              capture, emit_held, emit_new;
  logic              spare_valid;
  logic [CHAR_W-1:0] spare_data;

  assign c      = rx_data & char_mask;
  assign either = (rx_sel == 2'b11) && (tx_sel == 2'b10 || tx_sel == 2'b01);
  assign paired = (rx_sel == 2'b11) && (tx_sel == 2'b11 || tx_sel == 2'b00);
  assign use1   = (rx_sel == 2'b10) || either;
  assign use2   = (rx_sel == 2'b01) || either;

  always_comb begin
    off_hit    = 1'b0;
    on_hit     = 1'b0;
    any_resume = 1'b0;
    emit_held  = 1'b0;
    emit_new   = 1'b0;
    capture    = 1'b0;
    state_nxt  = state;
    if (rx_valid) begin
      if (halted && resume_any_en) begin
        any_resume = 1'b1;
        emit_held  = (state != SEQ_IDLE);
        emit_new   = 1'b1;
        state_nxt  = SEQ_IDLE;
      end else if (paired) begin
        if (state == SEQ_OFF1 && c == k_off2) begin
          off_hit   = 1'b1;
          state_nxt = SEQ_IDLE;
        end else if (state == SEQ_ON1 && c == k_on2) begin
          on_hit    = 1'b1;
          state_nxt = SEQ_IDLE;
        end else begin
          emit_held = (state != SEQ_IDLE);
          if (c == k_off1) begin
            capture   = 1'b1;
            state_nxt = SEQ_OFF1;
          end else if (c == k_on1) begin
            capture   = 1'b1;
            state_nxt = SEQ_ON1;
          end else begin
            emit_new  = 1'b1;
            state_nxt = SEQ_IDLE;
          end
        end
      end else if ((use1 && c == k_off1) || (use2 && c == k_off2)) begin
        off_hit = 1'b1;
      end else if ((use1 && c == k_on1) || (use2 && c == k_on2)) begin
        on_hit = 1'b1;
      end else begin
        emit_new = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      held  <= '0;
    end else begin
      state <= state_nxt;
      if (capture) held <= rx_data;
    end
  end

  // two-slot release: withheld character first, the new one a cycle later
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid   <= 1'b0;
      fwd_data    <= '0;
      spare_valid <= 1'b0;
      spare_data  <= '0;
    end else if (emit_held) begin
      fwd_valid   <= 1'b1;
      fwd_data    <= held;
      spare_valid <= emit_new;
      spare_data  <= rx_data;
    end else if (emit_new) begin
      fwd_valid   <= 1'b1;
      fwd_data    <= rx_data;
      spare_valid <= 1'b0;
    end else if (spare_valid) begin
      fwd_valid   <= 1'b1;
      fwd_data    <= spare_data;
      spare_valid <= 1'b0;
    end else begin
      fwd_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/sfc_tx_insert.sv
module sfc_tx_insert import sfc_pkg::*; #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        tx_sel,
  input  logic              above_halt,
  input  logic              at_resume,
  input  logic [CHAR_W-1:0] k_on1,
  input  logic [CHAR_W-1:0] k_on2,
  input  logic [CHAR_W-1:0] k_off1,
  input  logic [CHAR_W-1:0] k_off2,
  input  logic              ins_ready,
  output logic              ins_valid,
  output logic [CHAR_W-1:0] ins_data
);
  ins_t              st;
  logic              stop_sent;
  logic              pair_q;
  logic [CHAR_W-1:0] second_q;

  assign ins_valid = (st != INS_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= INS_IDLE;
      stop_sent <= 1'b0;
      pair_q    <= 1'b0;
      second_q  <= '0;
      ins_data  <= '0;
    end else begin
      case (st)
        INS_IDLE: begin
          if (tx_sel != 2'b00) begin
            if (!stop_sent && above_halt) begin
              st        <= INS_FIRST;
              stop_sent <= 1'b1;
              pair_q    <= &tx_sel;
              ins_data  <= tx_sel[1] ? k_off1 : k_off2;
              second_q  <= k_off2;
            end else if (stop_sent && at_resume) begin
              st        <= INS_FIRST;
              stop_sent <= 1'b0;
              pair_q    <= &tx_sel;
              ins_data  <= tx_sel[1] ? k_on1 : k_on2;
              second_q  <= k_on2;
            end
          end
        end
        INS_FIRST: begin
          if (ins_ready) begin
            if (pair_q) begin
              st       <= INS_SECOND;
              ins_data <= second_q;
            end else begin
              st <= INS_IDLE;
            end
          end
        end
        INS_SECOND: begin
          if (ins_ready) st <= INS_IDLE;
        end
        default: st <= INS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfc_flags.sv
module sfc_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic off_hit,
  input  logic on_hit,
  input  logic any_resume,
  input  logic special_hit,
  input  logic irq_en,
  input  logic iir_read,
  output logic tx_halt,
  output logic xoff_irq
);
  logic flow_flag, spec_flag;

  assign xoff_irq = flow_flag | spec_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_halt   <= 1'b0;
      flow_flag <= 1'b0;
      spec_flag <= 1'b0;
    end else begin
      if (off_hit) begin
        tx_halt <= 1'b1;
        if (irq_en) flow_flag <= 1'b1;
      end else if (on_hit || any_resume) begin
        tx_halt   <= 1'b0;
        flow_flag <= 1'b0;
      end
      if (special_hit && irq_en) spec_flag <= 1'b1;
      else if (iir_read)         spec_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sfc_flow_ctrl.sv
module sfc_flow_ctrl import sfc_pkg::*; #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic [3:0]        fc_mode,
  input  logic              xon_any_en,
  input  logic              special_en,
  input  logic              xoff_irq_en,
  input  logic [1:0]        word_len,
  input  logic [CHAR_W-1:0] xon1_char,
  input  logic [CHAR_W-1:0] xon2_char,
  input  logic [CHAR_W-1:0] xoff1_char,
  input  logic [CHAR_W-1:0] xoff2_char,
  input  logic              rx_above_halt,
  input  logic              rx_at_resume,
  input  logic              iir_read,
  input  logic              ins_ready,
  output logic              ins_valid,
  output logic [CHAR_W-1:0] ins_data,
  output logic              fwd_valid,
  output logic [CHAR_W-1:0] fwd_data,
  output logic              tx_halt,
  output logic              xoff_irq
);
  logic [CHAR_W-1:0] char_mask;
  logic [CHAR_W-1:0] m_on1, m_on2, m_off1, m_off2;
  logic              off_hit, on_hit, any_resume, special_hit;

  always_comb begin
    for (int i = 0; i < CHAR_W; i++)
      char_mask[i] = (i < MIN_WORD_BITS + int'(word_len));
  end

  assign m_on1  = xon1_char  & char_mask;
  assign m_on2  = xon2_char  & char_mask;
  assign m_off1 = xoff1_char & char_mask;
  assign m_off2 = xoff2_char & char_mask;
  assign special_hit = rx_valid && special_en && ((rx_data & char_mask) == m_off2);

  sfc_rx_match #(.CHAR_W(CHAR_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .char_mask(char_mask), .k_on1(m_on1), .k_on2(m_on2), .k_off1(m_off1),
    .k_off2(m_off2), .rx_sel(fc_mode[1:0]), .tx_sel(fc_mode[3:2]),
    .halted(tx_halt), .resume_any_en(xon_any_en), .off_hit(off_hit),
    .on_hit(on_hit), .any_resume(any_resume), .fwd_valid(fwd_valid),
    .fwd_data(fwd_data)
  );

  sfc_tx_insert #(.CHAR_W(CHAR_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_sel(fc_mode[3:2]),
    .above_halt(rx_above_halt), .at_resume(rx_at_resume),
    .k_on1(m_on1), .k_on2(m_on2), .k_off1(m_off1), .k_off2(m_off2),
    .ins_ready(ins_ready), .ins_valid(ins_valid), .ins_data(ins_data)
  );

  sfc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .off_hit(off_hit), .on_hit(on_hit),
    .any_resume(any_resume), .special_hit(special_hit), .irq_en(xoff_irq_en),
    .iir_read(iir_read), .tx_halt(tx_halt), .xoff_irq(xoff_irq)
  );
endmodule

// File: rtl/sfc_flow_checker.sv
module sfc_flow_checker #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic [3:0]        fc_mode,
  input logic              iir_read,
  input logic              ins_ready,
  input logic              ins_valid,
  input logic [CHAR_W-1:0] ins_data,
  input logic              fwd_valid,
  input logic              tx_halt,
  input logic              xoff_irq
);
  // R11: strobes are spaced by at least one idle cycle
  a_r11_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R11: forwarded output only follows a strobe or a preceding release
  a_r11_fwd_source: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> ($past(rx_valid) || $past(fwd_valid)));

  // R9: offered flow character held until taken
  a_r9_ins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready) |=> (ins_valid && $stable(ins_data)));

  // R8: nothing launched when the transmit field is zero
  a_r8_no_insert_off: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_mode[3:2] == 2'b00 && !ins_valid) |=> !ins_valid);

  // R3: halt rises only in the cycle after a strobe
  a_r3_halt_from_char: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_halt) |-> $past(rx_valid));

  // R2: with no receive compare a character cannot halt
  a_r2_no_compare_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && fc_mode[1:0] == 2'b00 && !tx_halt) |=> !tx_halt);

  // R7: identification read clears the flag when not halted
  a_r7_iir_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_read && !rx_valid && !tx_halt) |=> !xoff_irq);
endmodule

bind sfc_flow_ctrl sfc_flow_checker #(.CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .fc_mode(fc_mode),
  .iir_read(iir_read), .ins_ready(ins_ready), .ins_valid(ins_valid),
  .ins_data(ins_data), .fwd_valid(fwd_valid), .tx_halt(tx_halt),
  .xoff_irq(xoff_irq)
);

// File: tb/sfc_flow_ctrl_bench.sv
`timescale 1ns/1ps
module sfc_flow_ctrl_bench;
  localparam int W = 8;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         rx_valid = 1'b0;
  logic [W-1:0] rx_data = '0;
  logic [3:0]   fc_mode = 4'b0000;
  logic         xon_any_en = 1'b0, special_en = 1'b0, xoff_irq_en = 1'b1;
  logic [1:0]   word_len = 2'b11;
  logic [W-1:0] xon1_char = 8'h11, xon2_char = 8'h91;
  logic [W-1:0] xoff1_char = 8'h13, xoff2_char = 8'h93;
  logic         rx_above_halt = 1'b0, rx_at_resume = 1'b0;
  logic         iir_read = 1'b0, ins_ready = 1'b0;
  logic         ins_valid, fwd_valid, tx_halt, xoff_irq;
  logic [W-1:0] ins_data, fwd_data;

  always #2.5 clk = ~clk;

  sfc_flow_ctrl #(.CHAR_W(W)) u_sfc_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .fc_mode(fc_mode), .xon_any_en(xon_any_en), .special_en(special_en),
    .xoff_irq_en(xoff_irq_en), .word_len(word_len), .xon1_char(xon1_char),
    .xon2_char(xon2_char), .xoff1_char(xoff1_char), .xoff2_char(xoff2_char),
    .rx_above_halt(rx_above_halt), .rx_at_resume(rx_at_resume),
    .iir_read(iir_read), .ins_ready(ins_ready), .ins_valid(ins_valid),
    .ins_data(ins_data), .fwd_valid(fwd_valid), .fwd_data(fwd_data),
    .tx_halt(tx_halt), .xoff_irq(xoff_irq)
  );

  int    n_vec = 0, n_bad = 0;
  string cur_req = "R1";
  bit    finished = 0;

  // behavioural reference state
  bit           m_halt, m_flow, m_spec, m_stop_out;
  int           m_pend;            // 0 none, 1 holding ON1, 2 holding OFF1
  logic [W-1:0] m_held;
  logic [W-1:0] fwd_q[$];
  logic [W-1:0] ins_q[$];
  bit           m_fv, m_iv;
  logic [W-1:0] m_fd, m_id;
  bit           ev_off, ev_on, ev_any, ev_spec;
  logic [W-1:0] c, a1, a2, b1, b2;
  int           rs, ts;
  bit           take1, take2, paired;

  function automatic logic [W-1:0] msk(input logic [W-1:0] v);
    int nb = 5 + int'(word_len);
    return v & W'((1 << nb) - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_halt = 0; m_flow = 0; m_spec = 0; m_stop_out = 0; m_pend = 0;
      m_held = '0; fwd_q.delete(); ins_q.delete(); m_fv = 0; m_iv = 0;
      m_fd = '0; m_id = '0;
    end else begin
      ev_off = 0; ev_on = 0; ev_any = 0; ev_spec = 0;
      if (rx_valid) begin
        c  = msk(rx_data);
        a1 = msk(xon1_char);  a2 = msk(xon2_char);
        b1 = msk(xoff1_char); b2 = msk(xoff2_char);
        rs = int'(fc_mode[1:0]); ts = int'(fc_mode[3:2]);
        paired = (rs == 3) && (ts == 0 || ts == 3);
        take1  = (rs == 2) || (rs == 3 && !paired);
        take2  = (rs == 1) || (rs == 3 && !paired);
        ev_spec = special_en && (c == b2);
        if (m_halt && xon_any_en) begin
          if (m_pend != 0) fwd_q.push_back(m_held);
          fwd_q.push_back(rx_data);
          m_pend = 0; ev_any = 1;
        end else if (paired) begin
          if (m_pend == 2 && c == b2) begin ev_off = 1; m_pend = 0; end
          else if (m_pend == 1 && c == a2) begin ev_on = 1; m_pend = 0; end
          else begin
            if (m_pend != 0) fwd_q.push_back(m_held);
            m_pend = 0;
            if (c == b1)      begin m_pend = 2; m_held = rx_data; end
            else if (c == a1) begin m_pend = 1; m_held = rx_data; end
            else fwd_q.push_back(rx_data);
          end
        end else if ((take1 && c == b1) || (take2 && c == b2)) ev_off = 1;
        else if ((take1 && c == a1) || (take2 && c == a2)) ev_on = 1;
        else fwd_q.push_back(rx_data);
      end
      if (ev_off) begin m_halt = 1; if (xoff_irq_en) m_flow = 1; end
      else if (ev_on || ev_any) begin m_halt = 0; m_flow = 0; end
      if (ev_spec && xoff_irq_en) m_spec = 1;
      else if (iir_read) m_spec = 0;
      // insert channel
      if (ins_q.size() == 0) begin
        ts = int'(fc_mode[3:2]);
        if (ts != 0 && !m_stop_out && rx_above_halt) begin
          m_stop_out = 1;
          ins_q.push_back(ts == 1 ? msk(xoff2_char) : msk(xoff1_char));
          if (ts == 3) ins_q.push_back(msk(xoff2_char));
        end else if (ts != 0 && m_stop_out && rx_at_resume) begin
          m_stop_out = 0;
          ins_q.push_back(ts == 1 ? msk(xon2_char) : msk(xon1_char));
          if (ts == 3) ins_q.push_back(msk(xon2_char));
        end
      end else if (ins_ready) begin
        void'(ins_q.pop_front());
      end
      m_iv = (ins_q.size() != 0);
      if (m_iv) m_id = ins_q[0];
      m_fv = (fwd_q.size() != 0);
      if (m_fv) m_fd = fwd_q.pop_front();
    end
  end

  task automatic cmp(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      cmp("tx_halt",   {{(W-1){1'b0}}, tx_halt},   {{(W-1){1'b0}}, m_halt});
      cmp("xoff_irq",  {{(W-1){1'b0}}, xoff_irq},  {{(W-1){1'b0}}, (m_flow | m_spec)});
      cmp("ins_valid", {{(W-1){1'b0}}, ins_valid}, {{(W-1){1'b0}}, m_iv});
      if (m_iv) cmp("ins_data", ins_data, m_id);
      cmp("fwd_valid", {{(W-1){1'b0}}, fwd_valid}, {{(W-1){1'b0}}, m_fv});
      if (m_fv) cmp("fwd_data", fwd_data, m_fd);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [W-1:0] ch);
    @(negedge clk); rx_valid = 1'b1; rx_data = ch;
    @(negedge clk); rx_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL %s watchdog actual=running expected=done", cur_req);
    finish_run();
  end

  initial begin
    cur_req = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R2"; fc_mode = 4'b0010;      // ON1/OFF1 only
    send(8'h41);
    cur_req = "R3"; send(8'h13);            // OFF1 halts, flag set
    cur_req = "R2"; send(8'h93);            // OFF2 not recognised here
    cur_req = "R4"; send(8'h11);            // ON1 resumes

    cur_req = "R2"; fc_mode = 4'b0001;      // ON2/OFF2 only
    send(8'h13); send(8'h93); send(8'h11); send(8'h91);
    fc_mode = 4'b1011;                      // either code
    send(8'h93); send(8'h11);
    xoff1_char = 8'h11;                     // stop and resume codes equal
    send(8'h11);                            // stop wins
    xoff1_char = 8'h13;
    send(8'h91);

    cur_req = "R3"; xoff_irq_en = 1'b0; fc_mode = 4'b0010;
    send(8'h13); send(8'h11);
    xoff_irq_en = 1'b1;

    cur_req = "R5"; fc_mode = 4'b0011;      // pair mode
    send(8'h13); send(8'h93);               // OFF1 OFF2 halts
    send(8'h11); send(8'h41);               // abort: 11 then 41 released
    send(8'h11); send(8'h13); send(8'h91);  // abort chain
    send(8'h11); send(8'h91);               // ON1 ON2 resumes
    fc_mode = 4'b1111;
    send(8'h13); send(8'h93); send(8'h11); send(8'h91);

    cur_req = "R6"; xon_any_en = 1'b1; fc_mode = 4'b0010;
    send(8'h13); send(8'h55);
    fc_mode = 4'b0011;
    send(8'h13); send(8'h93); send(8'h66);
    xon_any_en = 1'b0;

    cur_req = "R7"; fc_mode = 4'b0000; special_en = 1'b1;
    send(8'h93); idle(2);
    @(negedge clk); iir_read = 1'b1;
    @(negedge clk); iir_read = 1'b0;
    idle(2);
    xoff_irq_en = 1'b0; send(8'h93); xoff_irq_en = 1'b1;
    special_en = 1'b0; send(8'h93);

    cur_req = "R8"; fc_mode = 4'b1000; ins_ready = 1'b0;
    @(negedge clk); rx_above_halt = 1'b1;
    cur_req = "R9"; idle(4);
    ins_ready = 1'b1; idle(2);
    cur_req = "R8"; rx_above_halt = 1'b0; rx_at_resume = 1'b1; idle(3);
    rx_at_resume = 1'b0; ins_ready = 1'b0;
    cur_req = "R9"; fc_mode = 4'b1100;
    rx_above_halt = 1'b1; idle(3);
    ins_ready = 1'b1; idle(1); ins_ready = 1'b0; idle(2);
    ins_ready = 1'b1; idle(2);
    rx_above_halt = 1'b0; rx_at_resume = 1'b1; idle(4);
    rx_at_resume = 1'b0;
    cur_req = "R8"; fc_mode = 4'b0100;
    rx_above_halt = 1'b1; idle(3); rx_above_halt = 1'b0;
    rx_at_resume = 1'b1; idle(3); rx_at_resume = 1'b0;
    fc_mode = 4'b0000; rx_above_halt = 1'b1; idle(4); rx_above_halt = 1'b0;

    cur_req = "R10"; word_len = 2'b00; fc_mode = 4'b0100;
    rx_above_halt = 1'b1; idle(3); rx_above_halt = 1'b0;
    rx_at_resume = 1'b1; idle(3); rx_at_resume = 1'b0;
    fc_mode = 4'b0010;
    send(8'hB3); send(8'h31);
    word_len = 2'b01;
    send(8'hB3);
    word_len = 2'b11;

    cur_req = "R11"; fc_mode = 4'b0011;
    send(8'h11); send(8'h22); send(8'h13); send(8'h13); send(8'h77);
    idle(4);
    finish_run();
  end
endmodule